// File: doc/BRIEF.md
# Register Read-Modify-Write Engine

This block applies one read-modify-write command to a register file outside it. A command arrives as three 32-bit words on a valid/ready stream. The engine then reads the target register and ORs an operand into its value. It ANDs the OR result with a second operand and writes the final value back to the same register.

Each of the two operands is either an immediate word from the payload or the contents of a register. A flag bit in the first word selects which, separately for each operand. In indirect mode, the low address bits of the operand word name the source register.

The register file is reached through one synchronous read port and one write port. The engine issues its reads one per cycle and only as many as the command needs. It raises a one-cycle completion strobe after the write-back and accepts no new payload until that strobe has been given.

Top module: `regrmw_engine`

## Requirements
- R1: The payload is three words, accepted one per cycle when `in_valid` and `in_ready` are both high, in this order: control word, AND word, OR word. Idle cycles with `in_valid` low may fall between words without changing the order.
- R2: The target register address is bits 12:0 of the control word, and bits 29:13 are ignored. The write-back goes to that same address.
- R3: When control bit 30 is 1, the OR operand is the register addressed by bits 12:0 of the OR word. When it is 0, the whole OR word is the OR operand.
- R4: When control bit 31 is 1, the AND operand is the register addressed by bits 12:0 of the AND word. When it is 0, the whole AND word is the AND operand.
- R5: The written value is (target OR or-operand) AND and-operand, with the OR applied first.
- R6: The target read is issued in the cycle after the third word is accepted. The indirect OR source read follows, only if bit 30 is set, and then the indirect AND source read, only if bit 31 is set. Reads are one per cycle, read data returns in the cycle after `rd_en`, and the write (`wr_en` for one cycle) comes in the cycle after the last read, never together with a read.
- R7: `done` is high for exactly one cycle, the cycle after the write.
- R8: From the cycle after the third word through the `done` cycle, `busy` is 1 and `in_ready` is 0. In the cycle after `done`, `busy` is 0 and `in_ready` is 1.
- R9: Reset gives `in_ready`=1 and `busy`, `done`, `rd_en`, `wr_en` all 0. Reset also discards a partly received payload, so the next accepted word is again the control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Payload word valid |
| in_ready | output | 1 | Engine can take a payload word |
| in_data | input | 32 | Payload word |
| rd_en | output | 1 | Register read request |
| rd_addr | output | 13 | Register read address |
| rd_data | input | 32 | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 13 | Register write address |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | A command is being executed |
| done | output | 1 | One-cycle completion strobe |

## Verification
The command is run with all four flag combinations, so that the read count, the read order and the write cycle are each shown to follow the two flags separately. Immediate words carry junk in bits 31:13 and the control word carries junk in bits 29:13. This shows that only the address field is decoded where an address is meant, and that the whole word is used where an immediate is meant. Complementary OR and AND masks give different answers depending on which operation comes first, and both operands pointing at the target register check the read-data bypass. A later command reads a register written by an earlier one, and a reset in the middle of a payload checks that the word counter restarts.

// File: rtl/regrmw_pkg.sv
package regrmw_pkg;
  localparam int unsigned PAYLOAD_BEATS = 3;
  localparam int unsigned BEAT_INFO     = 0;
  localparam int unsigned BEAT_AND      = 1;
  localparam int unsigned BEAT_OR       = 2;
  localparam int unsigned OR_IND_BIT    = 30;
  localparam int unsigned AND_IND_BIT   = 31;

  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_RD_TGT,
    ST_RD_OR,
    ST_RD_AND,
    ST_WRITE,
    ST_DONE
  } rmw_state_e;

  typedef enum logic [1:0] {
    SLOT_NONE,
    SLOT_TGT,
    SLOT_OR,
    SLOT_AND
  } rd_slot_e;
endpackage

// File: rtl/regrmw_collect.sv
module regrmw_collect #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BEATS  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accept_en,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [DATA_W-1:0]           in_data,
  output logic [BEATS-1:0][DATA_W-1:0] words,
  output logic                        payload_done
);
  localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] word_q [BEATS];
  logic              fire;
  logic              last_beat;

  assign in_ready     = accept_en;
  assign fire         = in_valid && accept_en;
  assign last_beat    = (cnt_q == CNT_W'(BEATS - 1));
  assign payload_done = fire && last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= last_beat ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BEATS; i++) word_q[i] <= '0;
    end else if (fire) begin
      for (int i = 0; i < BEATS; i++) begin
        if (cnt_q == CNT_W'(i)) word_q[i] <= in_data;
      end
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_word_out
    assign words[g] = word_q[g];
  end
endmodule

// File: rtl/regrmw_seq.sv
module regrmw_seq
  import regrmw_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              or_ind,
  input  logic              and_ind,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [ADDR_W-1:0] or_addr,
  input  logic [ADDR_W-1:0] and_addr,
  output logic              accept_en,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output rd_slot_e          rd_slot,
  output logic              wr_en,
  output logic              done
);
  rmw_state_e state_q, state_d;

  function automatic rmw_state_e after_target(input logic oi, input logic ai);
    if (oi)      return ST_RD_OR;
    else if (ai) return ST_RD_AND;
    else         return ST_WRITE;
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_COLLECT: if (start) state_d = ST_RD_TGT;
      ST_RD_TGT:  state_d = after_target(or_ind, and_ind);
      ST_RD_OR:   state_d = and_ind ? ST_RD_AND : ST_WRITE;
      ST_RD_AND:  state_d = ST_WRITE;
      ST_WRITE:   state_d = ST_DONE;
      ST_DONE:    state_d = ST_COLLECT;
      default:    state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_COLLECT;
    else        state_q <= state_d;
  end

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = '0;
    rd_slot = SLOT_NONE;
    case (state_q)
      ST_RD_TGT: begin rd_en = 1'b1; rd_addr = tgt_addr; rd_slot = SLOT_TGT; end
      ST_RD_OR:  begin rd_en = 1'b1; rd_addr = or_addr;  rd_slot = SLOT_OR;  end
      ST_RD_AND: begin rd_en = 1'b1; rd_addr = and_addr; rd_slot = SLOT_AND; end
      default:   ;
    endcase
  end

  assign accept_en = (state_q == ST_COLLECT);
  assign busy      = (state_q != ST_COLLECT);
  assign wr_en     = (state_q == ST_WRITE);
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/regrmw_datapath.sv
module regrmw_datapath
  import regrmw_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  rd_slot_e          rd_slot,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              or_ind,
  input  logic              and_ind,
  input  logic [DATA_W-1:0] or_imm,
  input  logic [DATA_W-1:0] and_imm,
  output logic [DATA_W-1:0] result
);
  rd_slot_e          fill_q;
  logic [DATA_W-1:0] tgt_q, orr_q, andr_q;
  logic [DATA_W-1:0] tgt_eff, orr_eff, andr_eff;
  logic [DATA_W-1:0] or_op, and_op;

  // Current value of a read slot: arriving data wins over the held copy.
  function automatic logic [DATA_W-1:0] slot_value(
      input logic arriving, input logic [DATA_W-1:0] rdat, input logic [DATA_W-1:0] held);
    return arriving ? rdat : held;
  endfunction

  function automatic logic [DATA_W-1:0] pick_operand(
      input logic indirect, input logic [DATA_W-1:0] reg_val, input logic [DATA_W-1:0] imm);
    return indirect ? reg_val : imm;
  endfunction

  function automatic logic [DATA_W-1:0] or_then_and(
      input logic [DATA_W-1:0] base, input logic [DATA_W-1:0] set_bits,
      input logic [DATA_W-1:0] keep_bits);
    return (base | set_bits) & keep_bits;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= SLOT_NONE;
      tgt_q  <= '0;
      orr_q  <= '0;
      andr_q <= '0;
    end else begin
      fill_q <= rd_en ? rd_slot : SLOT_NONE;
      tgt_q  <= tgt_eff;
      orr_q  <= orr_eff;
      andr_q <= andr_eff;
    end
  end

  assign tgt_eff  = slot_value(fill_q == SLOT_TGT, rd_data, tgt_q);
  assign orr_eff  = slot_value(fill_q == SLOT_OR,  rd_data, orr_q);
  assign andr_eff = slot_value(fill_q == SLOT_AND, rd_data, andr_q);
  assign or_op    = pick_operand(or_ind,  orr_eff,  or_imm);
  assign and_op   = pick_operand(and_ind, andr_eff, and_imm);
  assign result   = or_then_and(tgt_eff, or_op, and_op);
endmodule

// File: rtl/regrmw_engine.sv
module regrmw_engine
  import regrmw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);
  logic [PAYLOAD_BEATS-1:0][DATA_W-1:0] words;
  logic              payload_done;
  logic              accept_en;
  logic              or_ind, and_ind;
  logic [ADDR_W-1:0] tgt_addr, or_addr, and_addr;
  logic [DATA_W-1:0] info_w, and_w, or_w;
  rd_slot_e          rd_slot;
  logic              unused_info_bits;

  assign info_w   = words[BEAT_INFO];
  assign and_w    = words[BEAT_AND];
  assign or_w     = words[BEAT_OR];
  assign tgt_addr = info_w[ADDR_W-1:0];
  assign or_addr  = or_w[ADDR_W-1:0];
  assign and_addr = and_w[ADDR_W-1:0];
  assign or_ind   = info_w[OR_IND_BIT];
  assign and_ind  = info_w[AND_IND_BIT];
  assign unused_info_bits = ^info_w[OR_IND_BIT-1:ADDR_W];

  regrmw_collect #(.DATA_W(DATA_W), .BEATS(PAYLOAD_BEATS)) u_collect (
    .clk(clk), .rst_n(rst_n), .accept_en(accept_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .words(words), .payload_done(payload_done)
  );

  regrmw_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(payload_done),
    .or_ind(or_ind), .and_ind(and_ind),
    .tgt_addr(tgt_addr), .or_addr(or_addr), .and_addr(and_addr),
    .accept_en(accept_en), .busy(busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_slot(rd_slot),
    .wr_en(wr_en), .done(done)
  );

  regrmw_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_slot(rd_slot),
    .rd_data(rd_data), .or_ind(or_ind), .and_ind(and_ind),
    .or_imm(or_w), .and_imm(and_w), .result(wr_data)
  );

  assign wr_addr = tgt_addr;
endmodule

// File: rtl/regrmw_checker.sv
module regrmw_checker #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic              busy,
  input logic              done,
  input logic              payload_done,
  input logic [ADDR_W-1:0] tgt_addr
);
  AST_FIRST_READ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    payload_done |=> (rd_en && rd_addr == tgt_addr)); // R6
  AST_NO_READ_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R6
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (done && !wr_en)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_NOT_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready); // R8
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    payload_done |=> busy); // R8
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (in_ready && !busy)); // R8
endmodule

bind regrmw_engine regrmw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en),
  .busy(busy), .done(done), .payload_done(payload_done),
  .tgt_addr(tgt_addr)
);

// File: tb/regrmw_engine_bench.sv
module regrmw_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        rd_en;
  logic [12:0] rd_addr;
  logic [31:0] rd_data;
  logic        wr_en;
  logic [12:0] wr_addr;
  logic [31:0] wr_data;
  logic        busy;
  logic        done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [31:0] mem [256];

  always #10 clk = ~clk;

  regrmw_engine u_regrmw_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  // Register file model: synchronous read, one cycle latency.
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr[7:0]];
    if (wr_en) mem[wr_addr[7:0]] <= wr_data;
  end

  // control, AND word, OR word
  localparam logic [95:0] VECS [8] = '{
    {32'h0000_0012, 32'hFFFF_00FF, 32'h0000_0F00},
    {32'h4000_0034, 32'hFFFF_FFFF, 32'h1234_0056},
    {32'h8000_0078, 32'hABC0_009A, 32'h8000_0001},
    {32'hC000_1F01, 32'h0000_0011, 32'h0000_0022},
    {32'h3FFF_E003, 32'h0F0F_0F0F, 32'hF0F0_F0F0},
    {32'hC000_0040, 32'h0000_0040, 32'h0000_0040},
    {32'h0000_0005, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h4000_0012, 32'hFFFF_FFFF, 32'h0000_0034}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rmw(input logic [31:0] t, input logic [31:0] o, input logic [31:0] a);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = a[i] ? (t[i] | o[i]) : 1'b0;
    return r;
  endfunction

  task automatic send_word(input logic [31:0] d, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic run_op(input logic [31:0] info, input logic [31:0] andw,
                        input logic [31:0] orw, input int gap, input string tag);
    logic [12:0] exp_rd [3];
    int nr;
    logic [31:0] tv, ov, av, res;
    string dtag;
    nr = 0;
    exp_rd[nr] = info[12:0]; nr++;
    if (info[30]) begin exp_rd[nr] = orw[12:0];  nr++; end
    if (info[31]) begin exp_rd[nr] = andw[12:0]; nr++; end
    tv  = mem[info[7:0]];
    ov  = info[30] ? mem[orw[7:0]]  : orw;
    av  = info[31] ? mem[andw[7:0]] : andw;
    res = model_rmw(tv, ov, av);
    if (tag != "")    dtag = tag;
    else if (info[30]) dtag = "R3";
    else if (info[31]) dtag = "R4";
    else               dtag = "R5";
    send_word(info, gap);
    send_word(andw, gap);
    send_word(orw, gap);
    for (int k = 1; k <= nr + 3; k++) begin
      @(negedge clk);
      if (k == 1) in_valid = 1'b0;
      if (k <= nr)
        chk(rd_en && rd_addr == exp_rd[k-1], "R6 read order",
            {18'd0, rd_en, rd_addr}, {18'd0, 1'b1, exp_rd[k-1]});
      else
        chk(!rd_en, "R6 no extra read", {31'd0, rd_en}, 32'd0);
      if (k == nr + 1) begin
        chk(wr_en, "R6 write cycle", {31'd0, wr_en}, 32'd1);
        chk(wr_addr == info[12:0], "R2 write address", {19'd0, wr_addr}, {19'd0, info[12:0]});
        chk(wr_data == res, dtag, wr_data, res);
      end else begin
        chk(!wr_en, "R7 single write", {31'd0, wr_en}, 32'd0);
      end
      chk(done == (k == nr + 2), "R7 done pulse", {31'd0, done}, {31'd0, (k == nr + 2)});
      if (k <= nr + 2)
        chk(busy && !in_ready, "R8 busy window", {30'd0, busy, in_ready}, 32'd2);
      else
        chk(!busy && in_ready, "R8 idle after done", {30'd0, busy, in_ready}, 32'd1);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(in_ready, "R9 ready", {31'd0, in_ready}, 32'd1);
    chk(!busy, "R9 busy", {31'd0, busy}, 32'd0);
    chk(!done, "R9 done", {31'd0, done}, 32'd0);
    chk(!rd_en && !wr_en, "R9 strobes", {30'd0, rd_en, wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !busy, "R9 after release", {30'd0, busy, in_ready}, 32'd1);

    for (int v = 0; v < 8; v++)
      run_op(VECS[v][95:64], VECS[v][63:32], VECS[v][31:0], 0, "");

    // R1: idle gaps between payload words
    run_op(32'hC000_0021, 32'h0000_0012, 32'h0000_0013, 2, "R1");
    run_op(32'h0000_0022, 32'h00FF_FF00, 32'h0F00_000F, 1, "R1");

    // R9: reset in the middle of a payload discards the partial words
    send_word(32'h4000_0030, 0);
    send_word(32'h8000_0031, 0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(in_ready && !busy, "R9 mid-payload reset", {30'd0, busy, in_ready}, 32'd1);
    rst_n = 1'b1;
    run_op(32'h0000_0033, 32'hF0F0_FFFF, 32'h0000_00F0, 0, "R9");

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule